// File: doc/BRIEF.md
# Boot-Remapping Address Decoder

This block turns a 32-bit master address into a target choice: one of six slave selects, an external chip-select index, or an abort. The top four address bits pick one of sixteen 256 MB banks. Eight consecutive banks go to the external bus with a chip-select number. The top bank goes to the peripheral bus. Bank 0 holds the on-chip memories and is decoded a second time, in 1 MB windows. All other banks abort.

Window 0 of bank 0, which holds address zero, is the boot window. It points at SRAM when software has set the remap bit. With the remap bit clear, it points at internal flash or at boot ROM, chosen by a boot-select pin. That pin is captured while reset is held and is frozen after reset is released. The ROM, flash, SRAM and USB host register windows also stay reachable at their own fixed places, whatever the remap bit and the boot bit hold. A strobed request is decoded and registered, and the result appears on the outputs one clock later.

Top module: `boot_addr_decoder`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, all outputs are zero. Reset also clears the remap bit.
- R2: A request with `valid_i` high at a clock edge shows its decode on the outputs after that edge. With `valid_i` low at an edge, `sel_o`, `cs_o` and `abort_o` are all zero after that edge.
- R3: Banks 1 to 8 (`addr_i[31:28]`) select the external bus, `sel_o[4]`, with `cs_o` = bank − 1. Bank 1 gives chip select 0 and bank 8 gives chip select 7.
- R4: Bank 15 selects the peripheral bus, `sel_o[5]`, over its whole 256 MB.
- R5: Banks 9 to 14 raise `abort_o` and select nothing.
- R6: Inside bank 0, `addr_i[27:20]` picks a window. Window 1 is ROM (`sel_o[0]`, 32 KB). Window 2 is flash (`sel_o[1]`, 512 KB). Window 3 is SRAM (`sel_o[2]`, 32 KB). Window 5 is the USB host registers (`sel_o[3]`, 16 KB). These windows do not depend on the remap bit or the boot bit.
- R7: With the remap bit clear, window 0 selects ROM when the captured boot bit is 0 and flash when it is 1.
- R8: A cycle with `remap_wr_i` high loads `remap_val_i` into the remap bit. The new value applies to requests from the next edge on. While the remap bit is 1, window 0 selects SRAM.
- R9: In bank 0, an offset at or beyond the size of the selected memory aborts. This holds for window 0 too, where the size is that of the memory the window points at. Any window number not listed in R6 also aborts.
- R10: The boot bit is sampled from `boot_sel_i` on every edge while reset is asserted. Changes on the pin after reset is released have no effect.
- R11: At most one bit of `sel_o` is set. `abort_o` never appears together with a select. `cs_o` is non-zero only with the external-bus select.

Top module port list:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| boot_sel_i | input | 1 | Boot-select level, captured during reset |
| remap_wr_i | input | 1 | Write strobe for the remap bit |
| remap_val_i | input | 1 | Value written to the remap bit |
| valid_i | input | 1 | Request strobe |
| addr_i | input | 32 | Master byte address |
| sel_o | output | 6 | One-hot slave select: ROM, flash, SRAM, USB host, external bus, peripherals |
| cs_o | output | 3 | External chip-select index |
| abort_o | output | 1 | Access to an unmapped location |

## Verification
The assertions assume that `valid_i`, `addr_i` and the remap controls are held low or stable while reset is asserted. They also assume that `boot_sel_i` has a known level by the last reset edge. The bench changes every input on the falling clock edge. It holds `valid_i` low through each reset. It sets the boot pin before releasing reset and changes it only afterwards, to show that such changes are ignored. Remap writes come one cycle apart from requests, so each decode sees a settled remap bit.

// File: rtl/boot_addr_decoder_pkg.sv
package boot_addr_decoder_pkg;

    localparam int NSLV       = 6;
    localparam int CS_W       = 3;

    localparam int SLV_ROM    = 0;
    localparam int SLV_FLASH  = 1;
    localparam int SLV_SRAM   = 2;
    localparam int SLV_UHP    = 3;
    localparam int SLV_EBI    = 4;
    localparam int SLV_PERIPH = 5;

    typedef struct packed {
        logic [NSLV-1:0] sel;
        logic [CS_W-1:0] cs;
        logic            abort;
    } dec_t;

endpackage

// File: rtl/remap_ctrl.sv
module remap_ctrl
    import boot_addr_decoder_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic boot_pin_i,
    input  logic wr_i,
    input  logic wval_i,
    output logic remap_o,
    output logic boot_o
);

    typedef struct packed {
        logic remap;
        logic boot;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    always_comb begin
        ctl_d = ctl_q;
        if (!rst_n) begin
            ctl_d.remap = 1'b0;
            ctl_d.boot  = boot_pin_i;
        end else if (wr_i) begin
            ctl_d.remap = wval_i;
        end
    end

    always_ff @(posedge clk) begin
        ctl_q <= ctl_d;
    end

    assign remap_o = ctl_q.remap;
    assign boot_o  = ctl_q.boot;

    AST_BOOT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> $stable(ctl_q.boot)); // R10

    AST_REMAP_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(wr_i)) |-> (ctl_q.remap == $past(wval_i))); // R8

endmodule

// File: rtl/bank_decoder.sv
module bank_decoder
    import boot_addr_decoder_pkg::*;
#(
    parameter int EBI_FIRST   = 1,
    parameter int EBI_COUNT   = 8,
    parameter int PERIPH_BANK = 15
) (
    input  logic [3:0] bank_i,
    output logic       internal_o,
    output dec_t       dec_o
);

    localparam int EBI_LAST = EBI_FIRST + EBI_COUNT - 1;

    always_comb begin
        dec_o      = '0;
        internal_o = (bank_i == 4'd0);
        if (int'(bank_i) >= EBI_FIRST && int'(bank_i) <= EBI_LAST) begin
            dec_o.sel[SLV_EBI] = 1'b1;
            dec_o.cs           = CS_W'(int'(bank_i) - EBI_FIRST);
        end else if (int'(bank_i) == PERIPH_BANK) begin
            dec_o.sel[SLV_PERIPH] = 1'b1;
        end else if (bank_i != 4'd0) begin
            dec_o.abort = 1'b1;
        end
    end

endmodule

// File: rtl/int_mem_decoder.sv
module int_mem_decoder
    import boot_addr_decoder_pkg::*;
#(
    parameter int ROM_AW    = 15,
    parameter int FLASH_AW  = 19,
    parameter int SRAM_AW   = 15,
    parameter int UHP_AW    = 14,
    parameter int ROM_WIN   = 1,
    parameter int FLASH_WIN = 2,
    parameter int SRAM_WIN  = 3,
    parameter int UHP_WIN   = 5
) (
    input  logic [27:0] ofs_i,
    input  logic        remap_i,
    input  logic        boot_i,
    output dec_t        dec_o
);

    localparam int NREG  = 4;
    localparam int WIN_W = 8;
    localparam int OFS_W = 20;
    localparam int REG_AW  [NREG] = '{ROM_AW, FLASH_AW, SRAM_AW, UHP_AW};
    localparam int REG_WIN [NREG] = '{ROM_WIN, FLASH_WIN, SRAM_WIN, UHP_WIN};

    logic [WIN_W-1:0] win;
    logic [OFS_W-1:0] ofs;
    logic [NREG-1:0]  fits;
    logic [NREG-1:0]  fixed_hit;
    logic [1:0]       zero_tgt;

    assign win = ofs_i[27:20];
    assign ofs = ofs_i[19:0];

    for (genvar g = 0; g < NREG; g++) begin : g_region
        localparam logic [OFS_W:0] LIMIT = (OFS_W+1)'(1) << REG_AW[g];
        assign fits[g]      = ({1'b0, ofs} < LIMIT);
        assign fixed_hit[g] = (win == WIN_W'(REG_WIN[g])) && fits[g];
    end

    always_comb begin
        if (remap_i)     zero_tgt = 2'(SLV_SRAM);
        else if (boot_i) zero_tgt = 2'(SLV_FLASH);
        else             zero_tgt = 2'(SLV_ROM);
    end

    always_comb begin
        dec_o = '0;
        if (win == '0) begin
            if (fits[zero_tgt]) dec_o.sel[zero_tgt] = 1'b1;
            else                dec_o.abort         = 1'b1;
        end else if (|fixed_hit) begin
            dec_o.sel[NREG-1:0] = fixed_hit;
        end else begin
            dec_o.abort = 1'b1;
        end
    end

endmodule

// File: rtl/boot_addr_decoder.sv
module boot_addr_decoder
    import boot_addr_decoder_pkg::*;
#(
    parameter int ROM_AW    = 15,
    parameter int FLASH_AW  = 19,
    parameter int SRAM_AW   = 15,
    parameter int UHP_AW    = 14
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            boot_sel_i,
    input  logic            remap_wr_i,
    input  logic            remap_val_i,
    input  logic            valid_i,
    input  logic [31:0]     addr_i,
    output logic [NSLV-1:0] sel_o,
    output logic [CS_W-1:0] cs_o,
    output logic            abort_o
);

    typedef struct packed {
        dec_t out;
    } st_t;

    st_t  st_d, st_q;
    logic remap_q, boot_q;
    logic bank0;
    dec_t bank_dec, int_dec;

    remap_ctrl u_ctl (
        .clk        (clk),
        .rst_n      (rst_n),
        .boot_pin_i (boot_sel_i),
        .wr_i       (remap_wr_i),
        .wval_i     (remap_val_i),
        .remap_o    (remap_q),
        .boot_o     (boot_q)
    );

    bank_decoder u_bank (
        .bank_i     (addr_i[31:28]),
        .internal_o (bank0),
        .dec_o      (bank_dec)
    );

    int_mem_decoder #(
        .ROM_AW   (ROM_AW),
        .FLASH_AW (FLASH_AW),
        .SRAM_AW  (SRAM_AW),
        .UHP_AW   (UHP_AW)
    ) u_int (
        .ofs_i   (addr_i[27:0]),
        .remap_i (remap_q),
        .boot_i  (boot_q),
        .dec_o   (int_dec)
    );

    always_comb begin
        st_d = '0;
        if (rst_n && valid_i) begin
            st_d.out = bank0 ? int_dec : bank_dec;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign sel_o   = st_q.out.sel;
    assign cs_o    = st_q.out.cs;
    assign abort_o = st_q.out.abort;

    AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sel_o)); // R11

    AST_ABORT_ALONE: assert property (@(posedge clk) disable iff (!rst_n)
        abort_o |-> (sel_o == '0)); // R11

    AST_CS_WITH_EBI: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_o != '0) |-> sel_o[SLV_EBI]); // R11

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(valid_i) |-> ((sel_o == '0) && !abort_o)); // R2

    AST_PERIPH_BANK: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(valid_i) && $past(addr_i[31:28]) == 4'hF)
        |-> sel_o[SLV_PERIPH]); // R4

    AST_ZERO_REMAP: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(valid_i) && $past(addr_i[31:20]) == 12'h000 && $past(remap_q))
        |-> (sel_o[SLV_SRAM] || abort_o)); // R8

endmodule

// File: tb/tb_boot_addr_decoder.sv
module tb_boot_addr_decoder;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        boot_sel_i;
    logic        remap_wr_i;
    logic        remap_val_i;
    logic        valid_i;
    logic [31:0] addr_i;
    logic [5:0]  sel_o;
    logic [2:0]  cs_o;
    logic        abort_o;

    int tests  = 0;
    int fails  = 0;
    int cycles = 0;

    localparam logic [5:0] S_ROM = 6'b000001, S_FLASH = 6'b000010, S_SRAM = 6'b000100,
                           S_UHP = 6'b001000, S_EBI   = 6'b010000, S_PER  = 6'b100000,
                           S_NONE = 6'b000000;

    boot_addr_decoder dut (
        .clk (clk), .rst_n (rst_n), .boot_sel_i (boot_sel_i),
        .remap_wr_i (remap_wr_i), .remap_val_i (remap_val_i),
        .valid_i (valid_i), .addr_i (addr_i),
        .sel_o (sel_o), .cs_o (cs_o), .abort_o (abort_o)
    );

    always #5 clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 20000) begin
            fails = fails + 1;
            tests = tests + 1;
            $display("FAIL watchdog: run did not end (actual %0d cycles, expected fewer)", cycles);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    task automatic check(input string req, input logic [5:0] es, input logic [2:0] ec, input logic ea);
        tests = tests + 1;
        if (sel_o !== es || cs_o !== ec || abort_o !== ea) begin
            fails = fails + 1;
            $display("FAIL %s: actual sel=%b cs=%0d abort=%b, expected sel=%b cs=%0d abort=%b",
                     req, sel_o, cs_o, abort_o, es, ec, ea);
        end
    endtask

    task automatic do_reset(input logic boot);
        @(negedge clk);
        rst_n = 1'b0; valid_i = 1'b0; remap_wr_i = 1'b0; remap_val_i = 1'b0;
        addr_i = '0; boot_sel_i = boot;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic access(input logic [31:0] a, input string req,
                          input logic [5:0] es, input logic [2:0] ec, input logic ea);
        @(negedge clk);
        valid_i = 1'b1; addr_i = a;
        @(negedge clk);
        valid_i = 1'b0;
        check(req, es, ec, ea);
    endtask

    task automatic write_remap(input logic v);
        @(negedge clk);
        remap_wr_i = 1'b1; remap_val_i = v;
        @(negedge clk);
        remap_wr_i = 1'b0;
    endtask

    task automatic t_reset;
        @(negedge clk);
        rst_n = 1'b0; valid_i = 1'b1; addr_i = 32'h1000_0000; boot_sel_i = 1'b0;
        remap_wr_i = 1'b0; remap_val_i = 1'b0;
        @(negedge clk);
        check("R1 in reset", S_NONE, 3'd0, 1'b0);
        valid_i = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after reset", S_NONE, 3'd0, 1'b0);
        access(32'h0000_0000, "R1 remap cleared by reset", S_ROM, 3'd0, 1'b0);
    endtask

    task automatic t_idle;
        @(negedge clk);
        valid_i = 1'b0; addr_i = 32'h3000_0000;
        @(negedge clk);
        check("R2 no strobe", S_NONE, 3'd0, 1'b0);
        @(negedge clk);
        valid_i = 1'b1; addr_i = 32'hF000_0000;
        @(negedge clk);
        addr_i = 32'h9000_0000;
        check("R2 back-to-back first", S_PER, 3'd0, 1'b0);
        @(negedge clk);
        valid_i = 1'b0;
        check("R2 back-to-back second", S_NONE, 3'd0, 1'b1);
        @(negedge clk);
        check("R2 strobe dropped", S_NONE, 3'd0, 1'b0);
    endtask

    task automatic t_banks;
        access(32'h1000_0000, "R3 cs0", S_EBI, 3'd0, 1'b0);
        access(32'h4123_4560, "R3 cs3", S_EBI, 3'd3, 1'b0);
        access(32'h8FFF_FFFC, "R3 cs7", S_EBI, 3'd7, 1'b0);
        access(32'hF000_0000, "R4 periph low", S_PER, 3'd0, 1'b0);
        access(32'hFFFF_F000, "R4 periph high", S_PER, 3'd0, 1'b0);
        access(32'h9000_0000, "R5 bank9", S_NONE, 3'd0, 1'b1);
        access(32'hE7FF_0000, "R5 bank14", S_NONE, 3'd0, 1'b1);
    endtask

    task automatic t_internal;
        access(32'h0010_0000, "R6 rom", S_ROM, 3'd0, 1'b0);
        access(32'h0010_7FFC, "R6 rom top", S_ROM, 3'd0, 1'b0);
        access(32'h0020_0000, "R6 flash", S_FLASH, 3'd0, 1'b0);
        access(32'h0027_FFFC, "R6 flash top", S_FLASH, 3'd0, 1'b0);
        access(32'h0030_0000, "R6 sram", S_SRAM, 3'd0, 1'b0);
        access(32'h0050_0000, "R6 uhp", S_UHP, 3'd0, 1'b0);
        access(32'h0010_8000, "R9 rom past end", S_NONE, 3'd0, 1'b1);
        access(32'h0028_0000, "R9 flash past end", S_NONE, 3'd0, 1'b1);
        access(32'h0050_4000, "R9 uhp past end", S_NONE, 3'd0, 1'b1);
        access(32'h0040_0000, "R9 window4 hole", S_NONE, 3'd0, 1'b1);
        access(32'h0100_0000, "R9 window16 hole", S_NONE, 3'd0, 1'b1);
    endtask

    task automatic t_zero_rom;
        access(32'h0000_0000, "R7 zero rom", S_ROM, 3'd0, 1'b0);
        access(32'h0000_7FFC, "R7 zero rom top", S_ROM, 3'd0, 1'b0);
        access(32'h0000_8000, "R9 zero rom past end", S_NONE, 3'd0, 1'b1);
    endtask

    task automatic t_remap;
        write_remap(1'b1);
        access(32'h0000_0000, "R8 remap sram", S_SRAM, 3'd0, 1'b0);
        access(32'h0000_8000, "R9 remap sram past end", S_NONE, 3'd0, 1'b1);
        access(32'h0010_0000, "R6 rom fixed under remap", S_ROM, 3'd0, 1'b0);
        access(32'h0020_0000, "R6 flash fixed under remap", S_FLASH, 3'd0, 1'b0);
        write_remap(1'b0);
        access(32'h0000_0000, "R8 remap cleared", S_ROM, 3'd0, 1'b0);
    endtask

    task automatic t_boot_flash;
        do_reset(1'b1);
        access(32'h0000_0000, "R7 zero flash", S_FLASH, 3'd0, 1'b0);
        access(32'h0007_FFFC, "R7 zero flash top", S_FLASH, 3'd0, 1'b0);
        @(negedge clk);
        boot_sel_i = 1'b0;
        access(32'h0000_0000, "R10 pin change ignored", S_FLASH, 3'd0, 1'b0);
        access(32'h0010_0000, "R6 rom fixed with flash boot", S_ROM, 3'd0, 1'b0);
        write_remap(1'b1);
        access(32'h0000_0000, "R8 remap over flash boot", S_SRAM, 3'd0, 1'b0);
    endtask

    initial begin
        rst_n = 1'b0; valid_i = 1'b0; addr_i = '0; boot_sel_i = 1'b0;
        remap_wr_i = 1'b0; remap_val_i = 1'b0;
        t_reset();
        t_idle();
        t_banks();
        t_internal();
        t_zero_rom();
        t_remap();
        t_boot_flash();
        do_reset(1'b0);
        access(32'h0000_0000, "R1 remap cleared after second reset", S_ROM, 3'd0, 1'b0);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule